// File: doc/BRIEF.md
# Palette DAC register sequencer

This block is the colour map of an 8-bit pseudocolour display. It holds 256 main palette entries and four overlay (cursor) colour entries. Each entry is an 8-bit red, green and blue triple. Software reaches the map through a small 32-bit register window. It first loads an entry index, then moves the three components through a data port one at a time. A shared red, green, blue sequencer steps through the components, and the index advances on its own after each blue component, so a run of entries can be loaded without reloading the index.

A separate combinational port serves the pixel pipeline. It takes a 9-bit entry number (0 to 255 for the main palette, 256 to 259 for the overlay colours) and returns the 24-bit colour of that entry.

Top module: `pal_dac_regs`

## Requirements
- R1: After reset every entry is black (0x000000) except entries 255, 256 and 258, which are white (0xFFFFFF). The index and the component pointer are cleared, so the pointer is on red of entry 0.
- R2: A write to word offset 0x0 loads the index from data bits 31:24 and returns the component pointer to red, even in the middle of a triple.
- R3: Writes to offset 0x4 store successive components of main entry `index`, in the order red, green, blue, each taken from data bits 31:24. A stored value shows on the pixel port in the cycle after the write.
- R4: The access that completes blue increments the index modulo 256 (255 wraps to 0) and returns the pointer to red.
- R5: Writes to offset 0xC store into overlay entry 256 + (index & 3). They use the same red, green, blue stepping and the same index increment.
- R6: bus_rdata_o always carries the component under the pointer of main entry `index` in bits 31:24, with bits 23:0 zero. A read strobe advances the pointer, and the index increments after blue.
- R7: Writes to offset 0x8, or to any address with bits 1:0 not zero, change neither the palette, the index nor the pointer.
- R8: A read or write whose byte enables are not all ones (4'hF) has no effect.
- R9: When read and write strobes are both high in one cycle, the write is carried out and the read does not advance the pointer.
- R10: pix_rgb_o = {red, green, blue} of entry pix_idx_i, combinationally. An entry number of 260 or more returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Byte address within the 16-byte window |
| bus_be_i | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata_i | input | 32 | Write data; bits 31:24 used |
| bus_rdata_o | output | 32 | Current component in bits 31:24 |
| pix_idx_i | input | 9 | Entry number requested by the pixel pipeline |
| pix_rgb_o | output | 24 | Colour of that entry, {R,G,B} |

## Verification
The hard case to observe is a sequencer position that is wrong by one step while the palette still looks correct. Ignored accesses, rejected byte enables and a read that collides with a write all leave no visible change by themselves. To expose them, each such stimulus is followed by a further data write, and its landing place is checked on the pixel port. If the pointer slipped, that component appears in the wrong lane or in the wrong entry. The index wrap from 255 to 0 and the overlay selection by the low index bits are reached by loading index 255 and indices 6 and 7 directly.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  localparam int unsigned COMP_W = 8;
  localparam int unsigned MAIN_N = 256;
  localparam int unsigned OVL_N  = 4;

  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_e;

  typedef enum logic [1:0] {
    OFS_INDEX = 2'd0,
    OFS_MAIN  = 2'd1,
    OFS_RSVD  = 2'd2,
    OFS_OVL   = 2'd3
  } ofs_e;
endpackage

// File: rtl/pal_dac_decode.sv
module pal_dac_decode
  import pal_dac_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [3:0] addr_i,
  input  logic [3:0] be_i,
  output logic       ld_idx_o,
  output logic       wr_main_o,
  output logic       wr_ovl_o,
  output logic       rd_adv_o
);
  logic full_word, aligned, wr_ok;
  ofs_e ofs;

  assign full_word = &be_i;
  assign aligned   = (addr_i[1:0] == 2'b00);
  assign ofs       = ofs_e'(addr_i[3:2]);
  assign wr_ok     = wr_i & full_word & aligned;

  assign ld_idx_o  = wr_ok && (ofs == OFS_INDEX);
  assign wr_main_o = wr_ok && (ofs == OFS_MAIN);
  assign wr_ovl_o  = wr_ok && (ofs == OFS_OVL);
  // write strobe blocks the read, even a rejected write
  assign rd_adv_o  = rd_i & full_word & ~wr_i;

  // R9
  wr_blocks_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !rd_adv_o);
  // R7
  one_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_idx_o, wr_main_o, wr_ovl_o, rd_adv_o}));
endmodule

// File: rtl/pal_dac_fsm.sv
module pal_dac_fsm
  import pal_dac_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [IDX_W-1:0] ld_val_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output comp_e            comp_o
);
  logic [IDX_W-1:0] idx_q;
  comp_e            comp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      comp_q <= COMP_RED;
    end else if (ld_i) begin
      idx_q  <= ld_val_i;
      comp_q <= COMP_RED;
    end else if (step_i) begin
      unique case (comp_q)
        COMP_RED: comp_q <= COMP_GRN;
        COMP_GRN: comp_q <= COMP_BLU;
        default: begin
          comp_q <= COMP_RED;
          idx_q  <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign comp_o = comp_q;

  // R2
  idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (comp_q == COMP_RED) && (idx_q == $past(ld_val_i)));
  // R4
  blue_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ld_i && comp_q == COMP_BLU) |=>
      (comp_q == COMP_RED) && (idx_q == $past(idx_q) + 1'b1));
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !ld_i) |=> $stable(idx_q) && $stable(comp_q));
endmodule

// File: rtl/pal_dac_store.sv
module pal_dac_store
  import pal_dac_pkg::*;
#(
  parameter int unsigned N_MAIN = MAIN_N,
  parameter int unsigned N_OVL  = OVL_N,
  parameter int unsigned CW     = COMP_W,
  localparam int unsigned ENT_N = N_MAIN + N_OVL,
  localparam int unsigned ENT_W = $clog2(ENT_N),
  localparam int unsigned RGB_W = 3 * CW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ENT_W-1:0] went_i,
  input  comp_e            wcomp_i,
  input  logic [CW-1:0]    wval_i,
  input  logic [ENT_W-1:0] rent_i,
  input  comp_e            rcomp_i,
  output logic [CW-1:0]    rval_o,
  input  logic [ENT_W-1:0] pent_i,
  output logic [RGB_W-1:0] prgb_o
);
  logic [RGB_W-1:0] ent_rgb [ENT_N];

  function automatic logic [RGB_W-1:0] rst_val(int unsigned e);
    // last main entry, first and third overlay start white
    if (e == N_MAIN - 1 || e == N_MAIN || e == N_MAIN + 2) return '1;
    return '0;
  endfunction

  for (genvar e = 0; e < ENT_N; e++) begin : g_ent
    logic [RGB_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q <= rst_val(e);
      else if (we_i && went_i == ENT_W'(e))
        q[(2 - int'(wcomp_i)) * CW +: CW] <= wval_i;
    end
    assign ent_rgb[e] = q;
  end

  logic [RGB_W-1:0] rsel;
  always_comb begin
    rsel = '0;
    if (int'(rent_i) < ENT_N) rsel = ent_rgb[rent_i];
    rval_o = rsel[(2 - int'(rcomp_i)) * CW +: CW];
  end

  always_comb begin
    prgb_o = '0;
    if (int'(pent_i) < ENT_N) prgb_o = ent_rgb[pent_i];
  end

  // R10
  pix_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(pent_i) >= ENT_N) |-> (prgb_o == '0));
endmodule

// File: rtl/pal_dac_regs.sv
module pal_dac_regs
  import pal_dac_pkg::*;
#(
  parameter int unsigned N_MAIN = MAIN_N,
  parameter int unsigned N_OVL  = OVL_N,
  parameter int unsigned CW     = COMP_W,
  localparam int unsigned ENT_N = N_MAIN + N_OVL,
  localparam int unsigned ENT_W = $clog2(ENT_N),
  localparam int unsigned IDX_W = $clog2(N_MAIN),
  localparam int unsigned OVL_W = $clog2(N_OVL),
  localparam int unsigned RGB_W = 3 * CW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [3:0]       bus_addr_i,
  input  logic [3:0]       bus_be_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [ENT_W-1:0] pix_idx_i,
  output logic [RGB_W-1:0] pix_rgb_o
);
  logic             ld_idx, wr_main, wr_ovl, rd_adv;
  logic [IDX_W-1:0] idx;
  comp_e            comp;
  logic [ENT_W-1:0] went;
  logic [CW-1:0]    rval;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata_i[31-CW:0];

  pal_dac_decode i_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .addr_i   (bus_addr_i),
    .be_i     (bus_be_i),
    .ld_idx_o (ld_idx),
    .wr_main_o(wr_main),
    .wr_ovl_o (wr_ovl),
    .rd_adv_o (rd_adv)
  );

  pal_dac_fsm #(.IDX_W(IDX_W)) i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (ld_idx),
    .ld_val_i(bus_wdata_i[31 -: IDX_W]),
    .step_i  (wr_main | wr_ovl | rd_adv),
    .idx_o   (idx),
    .comp_o  (comp)
  );

  // overlay entries follow the main palette, selected by low index bits
  assign went = wr_ovl ? ENT_W'(N_MAIN) + ENT_W'(idx[OVL_W-1:0]) : ENT_W'(idx);

  pal_dac_store #(.N_MAIN(N_MAIN), .N_OVL(N_OVL), .CW(CW)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_main | wr_ovl),
    .went_i (went),
    .wcomp_i(comp),
    .wval_i (bus_wdata_i[31 -: CW]),
    .rent_i (ENT_W'(idx)),
    .rcomp_i(comp),
    .rval_o (rval),
    .pent_i (pix_idx_i),
    .prgb_o (pix_rgb_o)
  );

  assign bus_rdata_o = {rval, {(32-CW){1'b0}}};

  // R5
  ovl_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ovl |-> (int'(went) >= N_MAIN) && (int'(went) < ENT_N));
endmodule

// File: tb/test_pal_dac_regs.sv
`timescale 1ns/1ps
module test_pal_dac_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0, bus_be = 4'hF;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [8:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pal_dac_regs i_pal_dac_regs (
    .clk_i(clk), .rst_ni(rst_ni), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_be_i(bus_be), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .pix_idx_i(pix_idx), .pix_rgb_o(pix_rgb)
  );

  task automatic bus_wr_t(input logic [3:0] a, input logic [7:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = {d, 24'h5A5A5A}; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic bus_rd_t(input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_rd = 1'b1; bus_be = be;
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'hF;
  endtask

  task automatic chk_pix(input logic [8:0] e, input logic [23:0] exp, input string req);
    pix_idx = e;
    #0.5;
    n_chk++;
    if (pix_rgb !== exp) begin
      n_bad++;
      $display("FAIL %s pix[%0d] actual=%h expected=%h", req, e, pix_rgb, exp);
    end
  endtask

  task automatic chk_rd(input logic [7:0] exp, input string req);
    #0.5;
    n_chk++;
    if (bus_rdata !== {exp, 24'h0}) begin
      n_bad++;
      $display("FAIL %s rdata actual=%h expected=%h", req, bus_rdata, {exp, 24'h0});
    end
  endtask

  task automatic t_reset;
    chk_pix(9'd0,   24'h000000, "R1");
    chk_pix(9'd254, 24'h000000, "R1");
    chk_pix(9'd255, 24'hFFFFFF, "R1");
    chk_pix(9'd256, 24'hFFFFFF, "R1");
    chk_pix(9'd257, 24'h000000, "R1");
    chk_pix(9'd258, 24'hFFFFFF, "R1");
    chk_pix(9'd259, 24'h000000, "R1");
    chk_rd(8'h00, "R1");
  endtask

  task automatic t_main_write;
    bus_wr_t(4'h0, 8'h10);
    bus_wr_t(4'h4, 8'hAA);
    chk_pix(9'h10, 24'hAA0000, "R3");
    bus_wr_t(4'h4, 8'hBB);
    bus_wr_t(4'h4, 8'hCC);
    chk_pix(9'h10, 24'hAABBCC, "R3");
    bus_wr_t(4'h4, 8'h12);
    chk_pix(9'h11, 24'h120000, "R4");
  endtask

  task automatic t_wrap;
    bus_wr_t(4'h0, 8'hFF);
    bus_wr_t(4'h4, 8'h01);
    bus_wr_t(4'h4, 8'h02);
    bus_wr_t(4'h4, 8'h03);
    chk_pix(9'd255, 24'h010203, "R4");
    bus_wr_t(4'h4, 8'h44);
    chk_pix(9'd0, 24'h440000, "R4");
  endtask

  task automatic t_reload;
    bus_wr_t(4'h0, 8'h40);
    bus_wr_t(4'h4, 8'h01);
    bus_wr_t(4'h0, 8'h40);
    bus_wr_t(4'h4, 8'h02);
    chk_pix(9'h40, 24'h020000, "R2");
    bus_wr_t(4'h4, 8'h03);
    chk_pix(9'h40, 24'h020300, "R2");
  endtask

  task automatic t_overlay;
    bus_wr_t(4'h0, 8'h06);
    bus_wr_t(4'hC, 8'h11);
    bus_wr_t(4'hC, 8'h22);
    bus_wr_t(4'hC, 8'h33);
    chk_pix(9'd258, 24'h112233, "R5");
    chk_pix(9'h06, 24'h000000, "R5");
    bus_wr_t(4'hC, 8'h44);
    bus_wr_t(4'hC, 8'h55);
    bus_wr_t(4'hC, 8'h66);
    chk_pix(9'd259, 24'h445566, "R5");
  endtask

  task automatic t_read;
    bus_wr_t(4'h0, 8'h10);
    chk_rd(8'hAA, "R6");
    bus_rd_t();
    chk_rd(8'hBB, "R6");
    bus_rd_t();
    chk_rd(8'hCC, "R6");
    bus_rd_t();
    chk_rd(8'h12, "R6");
  endtask

  task automatic t_ignored;
    bus_wr_t(4'h0, 8'h20);
    bus_wr_t(4'h8, 8'hFF);
    bus_wr_t(4'h5, 8'hFF);
    chk_pix(9'h20, 24'h000000, "R7");
    bus_wr_t(4'h4, 8'h77);
    chk_pix(9'h20, 24'h770000, "R7");
  endtask

  task automatic t_byte_en;
    bus_wr_t(4'h4, 8'h55, 4'h7);
    bus_rd_t(4'h3);
    chk_pix(9'h20, 24'h770000, "R8");
    bus_wr_t(4'h4, 8'h66);
    chk_pix(9'h20, 24'h776600, "R8");
  endtask

  task automatic t_collide;
    bus_wr_t(4'h0, 8'h30);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 4'h4; bus_wdata = {8'h99, 24'h0};
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk_pix(9'h30, 24'h990000, "R9");
    bus_wr_t(4'h4, 8'h88);
    chk_pix(9'h30, 24'h998800, "R9");
  endtask

  task automatic t_range;
    chk_pix(9'd260, 24'h000000, "R10");
    chk_pix(9'd511, 24'h000000, "R10");
  endtask

  initial begin
    #12;
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_main_write();
    t_wrap();
    t_reload();
    t_overlay();
    t_read();
    t_ignored();
    t_byte_en();
    t_collide();
    t_range();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule